// File: doc/BRIEF.md
# Windowed Interrupt Burst Limiter

This block stands between a set of raw interrupt request lines and an interrupt controller. Each line has its own burst budget: at most `n` events may pass within any sliding interval of `W` time units. Each time a request is let through, the value of an external free-running time counter is written into that line's small ring of timestamps. A line whose ring holds `n` timestamps that are still inside the window is masked, and further requests on it are refused. When the oldest stored timestamp has aged to `W` or more, it is retired, which unmasks the line.

Since each line admits a bounded number of events per window, the handling load that reaches the controller never exceeds the sum over all lines of `n` times the cost of one event, however fast or however many the sources that storm. Requests that arrive while a line is masked set a sticky per-line flag. Software clears that flag with a write-one-to-clear pulse.

Top module: `irq_burst_limiter`

## Requirements
- R1: After reset, `irq_out` and `drop_flag` are all zero, no timestamps are held, and `line_masked` is high only for lines whose configured count is 0.
- R2: An event is a low-to-high transition of `irq_raw[i]`, so a request held high counts once. An admitted event makes `irq_out[i]` high for exactly the one cycle that follows the clock edge at which the transition is first seen.
- R3: When an event arrives on a line whose count of in-window timestamps, after any retirement in the same cycle, is below its effective limit, the event is admitted, `time_now` is stored for it, and the count goes up by one.
- R4: `line_masked[i]` is high whenever the line's in-window count is at or above its effective limit. While the line is masked and no retirement happens in that cycle, an event is not forwarded.
- R5: The oldest stored timestamp of a line is retired in the cycle where `time_now - ts >= cfg_window[i]`. This lowers the count by one. An admission may take place in the same cycle as a retirement.
- R6: The age is computed as the difference modulo 2^TIME_W, so the window test stays correct when `time_now` wraps past zero.
- R7: The effective limit is `cfg_max_n[i]` clamped to DEPTH. A limit of 0 keeps the line masked at all times. The in-window count never exceeds DEPTH.
- R8: `drop_flag[i]` is set by an event that is refused and stays set until a cycle with `drop_clr[i]` high. If a refusal and a clear happen in the same cycle, the flag is set.
- R9: Lines are independent: events, timestamps and flags on one line do not affect any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_raw | input | NUM_LINES | Raw request lines |
| time_now | input | TIME_W | Free-running time counter value |
| cfg_max_n | input | NUM_LINES*CNT_W | Per-line event limit; line i at bits [i*CNT_W +: CNT_W] |
| cfg_window | input | NUM_LINES*TIME_W | Per-line window length; line i at bits [i*TIME_W +: TIME_W] |
| drop_clr | input | NUM_LINES | Write-one-to-clear pulse for the drop flags |
| irq_out | output | NUM_LINES | Filtered requests, one-cycle pulse per admitted event |
| line_masked | output | NUM_LINES | Line is at its burst limit |
| drop_flag | output | NUM_LINES | Sticky flag: an event was refused |

## Verification
The bench targets the cycle in which a retirement and a fresh event coincide. A design that retires only after it has tested the limit would drop an event that should pass. Ages are taken across a wrap of the time counter, where a signed or non-modular compare would release the line too early. A limit of 7 against a four-entry ring checks the clamp, since an unclamped limit would overfill the ring and never mask. A request held high over several cycles, and a refusal that lands in the same cycle as a clear, expose double counting and the wrong priority between set and clear.

// File: rtl/irq_bl_pkg.sv
package irq_bl_pkg;
   // Default geometry shared by the limiter and its lanes
   localparam int unsigned BL_DEF_LINES = 4;
   localparam int unsigned BL_DEF_TIME_W = 16;
   localparam int unsigned BL_DEF_CNT_W = 3;
   localparam int unsigned BL_DEF_DEPTH = 4;

   function automatic bit bl_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/irq_bl_edge.sv
module irq_bl_edge #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_in,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_in;
   end

   assign rise = lvl_in & ~lvl_q;
endmodule

// File: rtl/irq_bl_lane.sv
module irq_bl_lane #(
   parameter int unsigned TIME_W = 16,
   parameter int unsigned CNT_W  = 3,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic [TIME_W-1:0] time_now,
   input  logic [CNT_W-1:0]  cfg_n,
   input  logic [TIME_W-1:0] cfg_win,
   input  logic              drop_clr,
   output logic              irq_out,
   output logic              masked,
   output logic              dropped
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned OCC_W = $clog2(DEPTH + 1);

   logic [TIME_W-1:0] ts_mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [OCC_W-1:0]  occ, lim, occ_avail;
   logic [TIME_W-1:0] age;
   logic              retire, admit;

   // Effective limit: configured count clamped to the ring depth
   always_comb begin
      if (int'(cfg_n) > int'(DEPTH)) lim = OCC_W'(DEPTH);
      else                           lim = OCC_W'(cfg_n);
   end

   // Modular age of the oldest entry survives counter wrap
   assign age       = time_now - ts_mem[rd_ptr];
   assign retire    = (occ != '0) && (age >= cfg_win);
   assign occ_avail = occ - OCC_W'(retire);
   assign admit     = rise && (occ_avail < lim);
   assign masked    = (occ >= lim);

   always_ff @(posedge clk) begin
      if (admit) ts_mem[wr_ptr] <= time_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         occ     <= '0;
         irq_out <= 1'b0;
         dropped <= 1'b0;
      end else begin
         irq_out <= admit;
         occ     <= occ + OCC_W'(admit) - OCC_W'(retire);
         if (admit)  wr_ptr <= wr_ptr + 1'b1;
         if (retire) rd_ptr <= rd_ptr + 1'b1;
         if (rise && !admit) dropped <= 1'b1;
         else if (drop_clr)  dropped <= 1'b0;
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= int'(DEPTH));

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |=> !irq_out);

   assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (masked && !retire) |=> !irq_out);

   assert_admit_logged_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (occ != '0));

   assert_drop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dropped && !drop_clr) |=> dropped);
endmodule

// File: rtl/irq_burst_limiter.sv
module irq_burst_limiter
   import irq_bl_pkg::*;
#(
   parameter int unsigned NUM_LINES = BL_DEF_LINES,
   parameter int unsigned TIME_W    = BL_DEF_TIME_W,
   parameter int unsigned CNT_W     = BL_DEF_CNT_W,
   parameter int unsigned DEPTH     = BL_DEF_DEPTH
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LINES-1:0]          irq_raw,
   input  logic [TIME_W-1:0]             time_now,
   input  logic [NUM_LINES*CNT_W-1:0]    cfg_max_n,
   input  logic [NUM_LINES*TIME_W-1:0]   cfg_window,
   input  logic [NUM_LINES-1:0]          drop_clr,
   output logic [NUM_LINES-1:0]          irq_out,
   output logic [NUM_LINES-1:0]          line_masked,
   output logic [NUM_LINES-1:0]          drop_flag
);
   initial begin
      assert (NUM_LINES >= 1) else $error("NUM_LINES must be at least 1");
      assert (DEPTH >= 2 && bl_is_pow2(DEPTH))
         else $error("DEPTH must be a power of two of at least 2");
      assert (TIME_W >= 2) else $error("TIME_W too narrow");
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
   end

   logic [NUM_LINES-1:0] rise;

   irq_bl_edge #(.WIDTH(NUM_LINES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_in (irq_raw),
      .rise   (rise)
   );

   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_lane
      irq_bl_lane #(
         .TIME_W (TIME_W),
         .CNT_W  (CNT_W),
         .DEPTH  (DEPTH)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .rise     (rise[gi]),
         .time_now (time_now),
         .cfg_n    (cfg_max_n[gi*CNT_W +: CNT_W]),
         .cfg_win  (cfg_window[gi*TIME_W +: TIME_W]),
         .drop_clr (drop_clr[gi]),
         .irq_out  (irq_out[gi]),
         .masked   (line_masked[gi]),
         .dropped  (drop_flag[gi])
      );
   end
endmodule

// File: tb/test_irq_burst_limiter.sv
`timescale 1ns/1ps
module test_irq_burst_limiter;
   localparam int NL = 4;
   localparam int TW = 16;
   localparam int CW = 3;
   localparam int NV = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_raw = '0;
   logic [TW-1:0] time_now = '0;
   logic [NL-1:0] drop_clr = '0;
   logic [NL-1:0] irq_out, line_masked, drop_flag;
   // line0 n=2 W=10, line1 n=1 W=5, line2 n=7 (clamps to 4) W=20, line3 n=0 W=5
   logic [NL*CW-1:0] cfg_max_n  = {3'd0, 3'd7, 3'd1, 3'd2};
   logic [NL*TW-1:0] cfg_window = {16'd5, 16'd20, 16'd5, 16'd10};

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   irq_burst_limiter i_irq_burst_limiter (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_raw    (irq_raw),
      .time_now   (time_now),
      .cfg_max_n  (cfg_max_n),
      .cfg_window (cfg_window),
      .drop_clr   (drop_clr),
      .irq_out    (irq_out),
      .line_masked(line_masked),
      .drop_flag  (drop_flag)
   );

   // {raw, time, clr, exp_out, exp_masked, exp_drop}
   localparam logic [35:0] VEC [NV] = '{
      {4'hF, 16'd0,  4'h0, 4'b0111, 4'b1010, 4'b1000}, // R3 admit, R7 n=0 refuses
      {4'h0, 16'd1,  4'h0, 4'b0000, 4'b1010, 4'b1000},
      {4'hF, 16'd2,  4'h0, 4'b0101, 4'b1011, 4'b1010}, // R4 line0 reaches limit
      {4'h0, 16'd3,  4'h0, 4'b0000, 4'b1011, 4'b1010},
      {4'hF, 16'd4,  4'h0, 4'b0100, 4'b1011, 4'b1011}, // R9 line2 alone passes
      {4'h0, 16'd5,  4'hF, 4'b0000, 4'b1001, 4'b0000}, // R5 line1 retires, R8 clear
      {4'hF, 16'd6,  4'h0, 4'b0110, 4'b1111, 4'b1001}, // R7 line2 full at 4
      {4'h0, 16'd7,  4'h0, 4'b0000, 4'b1111, 4'b1001},
      {4'hF, 16'd8,  4'h0, 4'b0000, 4'b1111, 4'b1111}, // R4 all refused
      {4'h0, 16'd10, 4'hF, 4'b0000, 4'b1110, 4'b0000}, // R5 line0 age equals W
      {4'hF, 16'd11, 4'h0, 4'b0011, 4'b1111, 4'b1100}, // R5 retire+admit same cycle
      {4'h0, 16'd12, 4'h0, 4'b0000, 4'b1110, 4'b1100}
   };

   task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input logic [NL-1:0] raw, input logic [TW-1:0] t,
                       input logic [NL-1:0] clr, input logic [NL-1:0] eo,
                       input logic [NL-1:0] em, input logic [NL-1:0] ed, input string tag);
      @(negedge clk);
      irq_raw  = raw;
      time_now = t;
      drop_clr = clr;
      @(posedge clk);
      #1;
      check({tag, " irq_out"}, irq_out, eo);
      check({tag, " line_masked"}, line_masked, em);
      check({tag, " drop_flag"}, drop_flag, ed);
   endtask

   task automatic do_reset();
      @(negedge clk);
      irq_raw = '0; drop_clr = '0; time_now = '0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 reset irq_out", irq_out, 4'b0000);
      check("R1 reset line_masked", line_masked, 4'b1000);
      check("R1 reset drop_flag", drop_flag, 4'b0000);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      do_reset();
      for (int k = 0; k < NV; k++) begin
         step(VEC[k][35:32], VEC[k][31:16], VEC[k][15:12],
              VEC[k][11:8], VEC[k][7:4], VEC[k][3:0], $sformatf("R3/R4/R5/R9 vec%0d", k));
      end

      // R1: reset clears every lane
      do_reset();

      // R2: a request held high counts once
      step(4'b0100, 16'd0, 4'h0, 4'b0100, 4'b1000, 4'b0000, "R2 held c0");
      step(4'b0100, 16'd1, 4'h0, 4'b0000, 4'b1000, 4'b0000, "R2 held c1");
      step(4'b0100, 16'd2, 4'h0, 4'b0000, 4'b1000, 4'b0000, "R2 held c2");
      step(4'b0000, 16'd3, 4'h0, 4'b0000, 4'b1000, 4'b0000, "R2 release");

      // R6: window test across time wrap on line1 (W=5)
      step(4'b0010, 16'hFFFE, 4'h0, 4'b0010, 4'b1010, 4'b0000, "R6 admit near wrap");
      step(4'b0000, 16'hFFFF, 4'h0, 4'b0000, 4'b1010, 4'b0000, "R6 idle");
      step(4'b0010, 16'h0002, 4'h0, 4'b0000, 4'b1010, 4'b0010, "R6 age4 refused");
      step(4'b0000, 16'h0003, 4'h0, 4'b0000, 4'b1000, 4'b0010, "R6 age5 retires");

      // R8: set wins over clear in the same cycle, then clear works
      step(4'b1000, 16'd4, 4'b1000, 4'b0000, 4'b1000, 4'b1010, "R8 set beats clear");
      step(4'b0000, 16'd5, 4'b1000, 4'b0000, 4'b1000, 4'b0010, "R8 clear line3");
      step(4'b0000, 16'd6, 4'b0010, 4'b0000, 4'b1000, 4'b0000, "R8 clear line1");

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule